// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block turns raw pin activity into interrupt requests. It serves two dedicated request pins and one group of eight pin-change inputs. Each dedicated pin has a two-bit sense selector, an enable, a sticky flag and a request output. The pin-change group has a per-pin mask, one group enable and one shared sticky flag.

Edge sensing on the dedicated pins uses two clocked sampling registers. It only counts while the clock-running input is high. Low-level sensing is a direct combinational view of the pin. Because of this, it can signal wake while the clock is stopped. A start-up-done input decides whether that level may also raise a request. Pin-change inputs pass through a capture register, a synchronizer register and a history register. Any masked difference between the last two sets the shared flag. Flags clear on a write-one strobe or on an acknowledge. Pin direction is invisible to the block, so a pin driven by the chip itself triggers in the same way.

Top module: `ext_irq_unit`

## Requirements
- R1: The sense field of dedicated channel i is `ded_sense[2i+1:2i]`. Its codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. A matching edge applied before clock edge k shows in `ded_flag` after clock edge k+1.
- R2: In low-level mode (00), `ded_irq` is high with no clock delay while the pin is low, the enable is 1 and `startup_done` is 1. It drops as soon as the pin goes high, and the flag is never set in this mode.
- R3: While `startup_done` is 0, a low level raises no request, but `wake` is still driven high by an enabled low-level channel.
- R4: An edge whose detection cycle has `clk_run` low is lost: the edge flag stays 0 after the clock resumes.
- R5: The pin-change flag sets on a toggle, in either direction, of an input whose `pc_mask` bit is 1. A toggle applied before clock edge k shows after clock edge k+2, not earlier. Toggles on unmasked inputs leave the flag at 0.
- R6: Pin-change detection ignores `clk_run`. With `pc_en` high, `wake` rises with no clock delay on a masked toggle.
- R7: Flags hold until a clear strobe (`ded_clr`, `pc_clr`) or an acknowledge (`ded_ack`, `pc_ack`) for that source. The flag is 0 after the next clock edge.
- R8: When a set and a clear or acknowledge meet on the same clock edge, the flag ends up 1.
- R9: An edge-mode or pin-change request is flag AND enable. The enable has no effect on setting the flag.
- R10: Synchronous active-low reset clears all flags. It loads every sampler with the present pin value, so pins that are high at reset release cause no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_run | input | 1 | High while the I/O clock runs; gates edge sensing |
| startup_done | input | 1 | High once start-up delay has ended; gates level requests |
| ded_pin | input | N_DED | Raw dedicated request pins |
| ded_sense | input | 2*N_DED | Sense selector, two bits per channel |
| ded_en | input | N_DED | Per-channel request enable |
| ded_clr | input | N_DED | Write-one-to-clear flag strobes |
| ded_ack | input | N_DED | Interrupt acknowledge per channel |
| pc_pin | input | N_PC | Raw pin-change inputs |
| pc_mask | input | N_PC | Per-pin change mask, 1 = watched |
| pc_en | input | 1 | Pin-change group enable |
| pc_clr | input | 1 | Write-one-to-clear for the group flag |
| pc_ack | input | 1 | Acknowledge for the group |
| ded_flag | output | N_DED | Sticky edge flags |
| pc_flag | output | 1 | Sticky shared pin-change flag |
| ded_irq | output | N_DED | Request per dedicated channel |
| pc_irq | output | 1 | Pin-change group request |
| wake | output | 1 | Wake request, valid without clock |

## Verification
The assertions assume that the sense selector, mask and enables are only changed while the pins they govern are steady. This way no sense change creates a spurious edge within the observation window. They also assume that clear and acknowledge strobes are single-cycle pulses. The stimulus follows these rules. It sets the configuration first, waits until the samplers have settled, clears any leftover flag, and only then moves one pin at a time at the falling clock edge. Each pin change is followed by the exact number of rising edges that the sampling pipeline needs before anything is checked.

// File: rtl/extint_pkg.sv
// Shared types for the external and pin-change interrupt unit.
// Assumes nothing beyond a two-bit sense selector per dedicated pin.
package extint_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_t;
endpackage

// File: rtl/ext_irq_ded_chan.sv
// One dedicated interrupt channel: a two-register edge sampler, a sense
// decoder, a sticky flag and a request output.
// Assumes: clk_run qualifies edge events; level mode bypasses the clock.
module ext_irq_ded_chan
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clk_run,
    input  logic   startup_done,
    input  logic   pin,
    input  sense_t sense,
    input  logic   en,
    input  logic   clr,
    input  logic   ack,
    output logic   flag,
    output logic   irq,
    output logic   level_wake
);
    logic samp_new;
    logic samp_old;
    logic rise_ev;
    logic fall_ev;
    logic hit;
    logic set_ev;
    logic level_low;

    // Sample the pin twice; reset loads the live value to avoid false edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_new <= pin;
            samp_old <= pin;
        end else begin
            samp_new <= pin;
            samp_old <= samp_new;
        end
    end

    assign rise_ev = samp_new & ~samp_old;
    assign fall_ev = ~samp_new & samp_old;

    // Decode which edge the sense selector asks for.
    always_comb begin
        case (sense)
            SENSE_ANY:  hit = rise_ev | fall_ev;
            SENSE_FALL: hit = fall_ev;
            SENSE_RISE: hit = rise_ev;
            default:    hit = 1'b0;
        endcase
    end

    assign set_ev = clk_run & hit;

    // Sticky flag: a set beats a clear or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr || ack) begin
            flag <= 1'b0;
        end
    end

    assign level_low  = (sense == SENSE_LOW) & ~pin;
    assign irq        = en & ((sense == SENSE_LOW) ? (level_low & startup_done) : flag);
    assign level_wake = en & level_low;

    a_r4_no_edge_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |=> !$rose(flag));
    a_r2_level_sets_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_LOW) |=> !$rose(flag));
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !ack) |=> flag);
    a_r9_edge_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sense != SENSE_LOW && irq) |-> flag);
endmodule

// File: rtl/ext_irq_pc_group.sv
// Pin-change group: each input passes a capture register, a synchronizer
// register and a history register; any masked difference sets one flag.
// Assumes: detection is not gated by the clock-running input.
module ext_irq_pc_group #(
    parameter int N_PC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PC-1:0] pin,
    input  logic [N_PC-1:0] mask,
    input  logic            en,
    input  logic            clr,
    input  logic            ack,
    output logic            flag,
    output logic            irq,
    output logic            change_wake
);
    logic [N_PC-1:0] cap_q;
    logic [N_PC-1:0] sync_q;
    logic [N_PC-1:0] hist_q;
    logic            set_ev;

    // Three-register pipeline per input, preloaded with the live pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= pin;
            sync_q <= pin;
            hist_q <= pin;
        end else begin
            cap_q  <= pin;
            sync_q <= cap_q;
            hist_q <= sync_q;
        end
    end

    assign set_ev = |(mask & (sync_q ^ hist_q));

    // Shared sticky flag: a set beats a clear or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr || ack) begin
            flag <= 1'b0;
        end
    end

    assign irq         = en & flag;
    assign change_wake = en & (|(mask & (pin ^ hist_q)));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && (clr || ack)) |=> flag);
    a_r7_pc_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !ack) |=> flag);
    a_r9_pc_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

// File: rtl/ext_irq_unit.sv
// Top of the interrupt unit: N_DED dedicated channels and one pin-change
// group, with a combined wake output usable while the clock is stopped.
// Assumes: configuration inputs change only while the governed pins are steady.
module ext_irq_unit
    import extint_pkg::*;
#(
    parameter int N_DED = 2,
    parameter int N_PC  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_run,
    input  logic               startup_done,
    input  logic [N_DED-1:0]   ded_pin,
    input  logic [2*N_DED-1:0] ded_sense,
    input  logic [N_DED-1:0]   ded_en,
    input  logic [N_DED-1:0]   ded_clr,
    input  logic [N_DED-1:0]   ded_ack,
    input  logic [N_PC-1:0]    pc_pin,
    input  logic [N_PC-1:0]    pc_mask,
    input  logic               pc_en,
    input  logic               pc_clr,
    input  logic               pc_ack,
    output logic [N_DED-1:0]   ded_flag,
    output logic               pc_flag,
    output logic [N_DED-1:0]   ded_irq,
    output logic               pc_irq,
    output logic               wake
);
    logic [N_DED-1:0] lvl_wake;
    logic             pc_wake;

    // One channel instance per dedicated pin.
    for (genvar i = 0; i < N_DED; i++) begin : g_ded
        ext_irq_ded_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .clk_run      (clk_run),
            .startup_done (startup_done),
            .pin          (ded_pin[i]),
            .sense        (sense_t'(ded_sense[2*i +: 2])),
            .en           (ded_en[i]),
            .clr          (ded_clr[i]),
            .ack          (ded_ack[i]),
            .flag         (ded_flag[i]),
            .irq          (ded_irq[i]),
            .level_wake   (lvl_wake[i])
        );
    end

    ext_irq_pc_group #(.N_PC(N_PC)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin         (pc_pin),
        .mask        (pc_mask),
        .en          (pc_en),
        .clr         (pc_clr),
        .ack         (pc_ack),
        .flag        (pc_flag),
        .irq         (pc_irq),
        .change_wake (pc_wake)
    );

    // Wake on any pending request, enabled low level or raw masked change.
    assign wake = (|lvl_wake) | pc_wake | (|ded_irq) | pc_irq;

    a_r3_request_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ded_irq) || pc_irq) |-> wake);
endmodule

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       clk_run, startup_done;
    logic [1:0] ded_pin, ded_en, ded_clr, ded_ack;
    logic [3:0] ded_sense;
    logic [7:0] pc_pin, pc_mask;
    logic       pc_en, pc_clr, pc_ack;
    logic [1:0] ded_flag, ded_irq;
    logic       pc_flag, pc_irq, wake;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .startup_done(startup_done),
        .ded_pin(ded_pin), .ded_sense(ded_sense), .ded_en(ded_en),
        .ded_clr(ded_clr), .ded_ack(ded_ack), .pc_pin(pc_pin), .pc_mask(pc_mask),
        .pc_en(pc_en), .pc_clr(pc_clr), .pc_ack(pc_ack), .ded_flag(ded_flag),
        .pc_flag(pc_flag), .ded_irq(ded_irq), .pc_irq(pc_irq), .wake(wake)
    );

    // Vector: {sense[1:0], pin_before, pin_after, expected_flag}
    localparam logic [4:0] VEC [9] = '{
        {2'b01, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr0();
        ded_clr[0] = 1'b1; tick(1); ded_clr[0] = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_run = 1'b1; startup_done = 1'b1;
        ded_pin = 2'b11; ded_sense = 4'h0; ded_en = 2'b00;
        ded_clr = 2'b00; ded_ack = 2'b00;
        pc_pin = 8'hA5; pc_mask = 8'hFF; pc_en = 1'b0; pc_clr = 1'b0; pc_ack = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(4);
        // R10: high pins at reset release cause no event
        check("R10 ded_flag", {6'd0, ded_flag}, 8'h00);
        check("R10 pc_flag", {7'd0, pc_flag}, 8'h00);
        check("R10 wake", {7'd0, wake}, 8'h00);

        // R1: vector table walked on channel 0
        pc_mask = 8'h00;
        foreach (VEC[i]) begin
            ded_sense[1:0] = VEC[i][4:3];
            ded_pin[0] = VEC[i][2];
            tick(3);
            clr0();
            ded_pin[0] = VEC[i][1];
            tick(2);
            check($sformatf("R1 vector %0d", i), {7'd0, ded_flag[0]}, {7'd0, VEC[i][0]});
        end

        // R2: level mode requests with no clock delay and sets no flag
        ded_sense[1:0] = 2'b00; ded_en[0] = 1'b1; ded_pin[0] = 1'b1; tick(3); clr0();
        ded_pin[0] = 1'b0; #1;
        check("R2 level irq", {7'd0, ded_irq[0]}, 8'h01);
        tick(2);
        check("R2 no flag", {7'd0, ded_flag[0]}, 8'h00);
        ded_pin[0] = 1'b1; #1;
        check("R2 irq drops", {7'd0, ded_irq[0]}, 8'h00);

        // R3: start-up not done blocks request but not wake
        startup_done = 1'b0; ded_pin[0] = 1'b0; #1;
        check("R3 irq blocked", {7'd0, ded_irq[0]}, 8'h00);
        check("R3 wake", {7'd0, wake}, 8'h01);
        tick(1);
        ded_pin[0] = 1'b1; startup_done = 1'b1; ded_en[0] = 1'b0;
        tick(3);

        // R4: falling edge while clock halted is lost
        ded_sense[1:0] = 2'b10; tick(2); clr0();
        clk_run = 1'b0; ded_pin[0] = 1'b0; tick(3);
        clk_run = 1'b1; tick(2);
        check("R4 edge lost", {7'd0, ded_flag[0]}, 8'h00);
        ded_pin[0] = 1'b1; tick(3);

        // R9: flag sets with enable low; request follows enable
        ded_pin[0] = 1'b0; tick(2);
        check("R9 flag set disabled", {7'd0, ded_flag[0]}, 8'h01);
        check("R9 irq off", {7'd0, ded_irq[0]}, 8'h00);
        ded_en[0] = 1'b1; #1;
        check("R9 irq on", {7'd0, ded_irq[0]}, 8'h01);

        // R7: flag holds, acknowledge clears it
        tick(5);
        check("R7 held", {7'd0, ded_flag[0]}, 8'h01);
        ded_ack[0] = 1'b1; tick(1); ded_ack[0] = 1'b0;
        check("R7 ack clears", {7'd0, ded_flag[0]}, 8'h00);

        // R8: set and clear on the same edge on channel 0
        ded_sense[1:0] = 2'b11; tick(1);
        ded_pin[0] = 1'b1; tick(1);
        ded_clr[0] = 1'b1; tick(1); ded_clr[0] = 1'b0;
        check("R8 ded set wins", {7'd0, ded_flag[0]}, 8'h01);
        clr0();
        check("R7 clr clears", {7'd0, ded_flag[0]}, 8'h00);

        // R1: any-change mode on channel 1
        ded_sense[3:2] = 2'b01; tick(1);
        ded_pin[1] = 1'b0; tick(2);
        check("R1 ch1 any change", {7'd0, ded_flag[1]}, 8'h01);

        // R5: masked and unmasked pin changes, pipeline latency
        pc_mask = 8'h04;
        pc_pin = pc_pin ^ 8'h08; tick(4);
        check("R5 unmasked ignored", {7'd0, pc_flag}, 8'h00);
        pc_pin = pc_pin ^ 8'h04; tick(2);
        check("R5 not yet", {7'd0, pc_flag}, 8'h00);
        tick(1);
        check("R5 masked toggle", {7'd0, pc_flag}, 8'h01);
        pc_clr = 1'b1; tick(1); pc_clr = 1'b0;
        check("R7 pc clr", {7'd0, pc_flag}, 8'h00);

        // R6: pin change works with clock halted and wakes at once
        clk_run = 1'b0; pc_en = 1'b1;
        pc_pin = pc_pin ^ 8'h04; #1;
        check("R6 wake", {7'd0, wake}, 8'h01);
        tick(3);
        check("R6 flag halted", {7'd0, pc_flag}, 8'h01);
        check("R9 pc irq", {7'd0, pc_irq}, 8'h01);
        pc_clr = 1'b1; tick(1); pc_clr = 1'b0;

        // R8: set and clear on the same edge in the group
        pc_pin = pc_pin ^ 8'h04; tick(2);
        pc_clr = 1'b1; tick(1); pc_clr = 1'b0;
        check("R8 pc set wins", {7'd0, pc_flag}, 8'h01);
        pc_ack = 1'b1; tick(1); pc_ack = 1'b0;
        check("R7 pc ack", {7'd0, pc_flag}, 8'h00);
        clk_run = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule